// File: doc/BRIEF.md
# Interrupt Mask and Serial Bit Controller

This block keeps the per-level mask bits, the pending state and a one-bit serial output for three prioritized hardware interrupt levels, called top, mid and low here. Software writes one control byte to change the masks, to drop a latched top-level request without servicing it, and to update the serial output pin. It reads back one status byte that packs the masks, the pending levels, the global enable flag and the serial input pin.

The top level latches on a rising edge of its input and stays pending until software clears it. The mid and low levels are level sensitive and are pending only while their inputs are high. A masked request output, with a one-hot grant vector that follows a fixed priority, tells the surrounding core that an unmasked level is pending while interrupts are globally enabled. Vectoring and acknowledge cycles are handled outside this block.

Top module: `irq_mask_ctl`

## Requirements
- R1: After reset, all three masks are 1 (masked), the top-level latch is clear, the serial output is 0 and global enable is 0. With all inputs low, the status byte reads 8'h07.
- R2: A control write with bit 3 set loads the masks from bits 2..0: bit 0 masks top, bit 1 masks mid, bit 2 masks low, and 1 means masked. The new masks show in the status byte after the clock edge.
- R3: A control write with bit 3 clear leaves all three masks unchanged.
- R4: A control write with bit 4 set clears the top-level latch. If a rising edge on the top input arrives in the same cycle, the latch ends up set.
- R5: The top-level latch sets on a rising edge of its input and stays set after the input falls. A steady high input does not set it again once it has been cleared.
- R6: The mid and low levels are pending exactly while their inputs are high, whether or not they are masked.
- R7: The serial output takes bit 7 of a control write only when bit 6 of that write is 1. Otherwise it holds its value.
- R8: The status byte is: bit 7 the serial input pin, bit 6 top pending, bit 5 mid pending, bit 4 low pending, bit 3 global enable, bits 2..0 the masks in the R2 order.
- R9: Global enable is set by a pulse on the set input and cleared by a pulse on the clear input. When both arrive in the same cycle, clear wins.
- R10: The request output is 1 when global enable is 1 and at least one pending level is unmasked. The grant vector is one-hot, with bit 2 top, bit 1 mid and bit 0 low. Top wins over mid, and mid wins over low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte |
| rd_data | output | 8 | Status byte |
| lvl_top | input | 1 | Edge-triggered top interrupt level |
| lvl_mid | input | 1 | Level-sensitive mid interrupt level |
| lvl_low | input | 1 | Level-sensitive low interrupt level |
| gie_set | input | 1 | Sets global enable |
| gie_clr | input | 1 | Clears global enable |
| ser_in | input | 1 | Serial input pin |
| ser_out | output | 1 | Serial output pin |
| irq_req | output | 1 | Masked interrupt request |
| irq_grant | output | 3 | One-hot winning level |

## Verification
The bench aims at the cycle in which a clear of the top latch and a new rising edge on the top input coincide. A design that gives the clear priority would lose that request, and bit 6 of the status byte would read 0. It also writes control bytes with bit 3 clear, and bytes that carry a serial bit while bit 6 is 0. A design that ignores either enable would change the masks or the serial output. Further cases are a steady-high top input after a clear, which must not set the latch again, and simultaneous enable and disable pulses, where a wrong priority would leave requests active. Masked-but-pending levels check that the status byte still reports them while the request output stays low.

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       lvl_top,
  input  logic       lvl_mid,
  input  logic       lvl_low,
  input  logic       gie_set,
  input  logic       gie_clr,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       irq_req,
  output logic [2:0] irq_grant
);

  logic [2:0] msk;
  logic       top_pend;
  logic       top_prev;
  logic       gie;
  logic       ser_q;
  logic       top_edge;
  logic [2:0] pend;
  logic [2:0] live;
  logic       unused_bit5;

  assign unused_bit5 = wr_data[5];
  assign top_edge    = lvl_top & ~top_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk      <= 3'b111;
      top_pend <= 1'b0;
      top_prev <= 1'b0;
      gie      <= 1'b0;
      ser_q    <= 1'b0;
    end else begin
      top_prev <= lvl_top;
      if (wr_en && wr_data[3]) msk <= wr_data[2:0];
      if (wr_en && wr_data[6]) ser_q <= wr_data[7];
      if (top_edge) top_pend <= 1'b1;
      else if (wr_en && wr_data[4]) top_pend <= 1'b0;
      if (gie_clr) gie <= 1'b0;
      else if (gie_set) gie <= 1'b1;
    end
  end

  assign pend      = {top_pend, lvl_mid, lvl_low};
  assign live      = pend & ~{msk[0], msk[1], msk[2]} & {3{gie}};
  assign irq_req   = |live;
  assign irq_grant = live[2] ? 3'b100 : live[1] ? 3'b010 : live[0] ? 3'b001 : 3'b000;
  assign ser_out   = ser_q;
  assign rd_data   = {ser_in, pend, gie, msk};

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3]) |=> $stable(rd_data[2:0]));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> (rd_data[2:0] == $past(wr_data[2:0])));

  p_top_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_top) |=> rd_data[6]);

  p_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4] && !(lvl_top && !$past(lvl_top))) |=> !rd_data[6]);

  p_ser_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[6]) |=> $stable(ser_out));

  p_gie_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !rd_data[3]);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_grant) && (irq_req == (irq_grant != 3'b000)));

  p_req_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |-> !irq_req);

endmodule

// File: tb/irq_mask_ctl_tb_top.sv
module irq_mask_ctl_tb_top;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       irq;
    logic [2:0] gnt;
    logic       ser;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic lvl_top = 1'b0, lvl_mid = 1'b0, lvl_low = 1'b0;
  logic gie_set = 1'b0, gie_clr = 1'b0, ser_in = 1'b0;
  logic ser_out, irq_req;
  logic [2:0] irq_grant;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t q[$];
  event mon_ev;

  logic [2:0] m_msk = 3'b111;
  logic m_top = 1'b0, m_prev = 1'b0, m_gie = 1'b0, m_ser = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lvl_top(lvl_top), .lvl_mid(lvl_mid), .lvl_low(lvl_low),
    .gie_set(gie_set), .gie_clr(gie_clr), .ser_in(ser_in),
    .ser_out(ser_out), .irq_req(irq_req), .irq_grant(irq_grant)
  );

  task automatic fail_line(string tag, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (rd_data !== e.rd || irq_req !== e.irq || irq_grant !== e.gnt || ser_out !== e.ser) begin
          if (rd_data !== e.rd) fail_line(e.tag, "rd_data", int'(rd_data), int'(e.rd));
          else if (irq_req !== e.irq) fail_line(e.tag, "irq_req", int'(irq_req), int'(e.irq));
          else if (irq_grant !== e.gnt) fail_line(e.tag, "irq_grant", int'(irq_grant), int'(e.gnt));
          else fail_line(e.tag, "ser_out", int'(ser_out), int'(e.ser));
        end
      end
    end
  end

  task automatic step(string tag, logic we, logic [7:0] wd, logic t, logic m, logic l,
                      logic si, logic gs, logic gc);
    exp_t e;
    logic [2:0] unm;
    @(negedge clk);
    wr_en = we; wr_data = wd; lvl_top = t; lvl_mid = m; lvl_low = l;
    ser_in = si; gie_set = gs; gie_clr = gc;
    if (we && wd[4]) m_top = 1'b0;
    if (t && !m_prev) m_top = 1'b1;
    m_prev = t;
    if (we && wd[3]) m_msk = wd[2:0];
    if (we && wd[6]) m_ser = wd[7];
    if (gc) m_gie = 1'b0;
    else if (gs) m_gie = 1'b1;
    @(posedge clk);
    #1;
    unm = {m_top & ~m_msk[0], m & ~m_msk[1], l & ~m_msk[2]};
    e.tag = tag;
    e.rd  = {si, m_top, m, l, m_gie, m_msk};
    e.irq = m_gie & (|unm);
    e.gnt = !m_gie ? 3'b000 : unm[2] ? 3'b100 : unm[1] ? 3'b010 : unm[0] ? 3'b001 : 3'b000;
    e.ser = m_ser;
    q.push_back(e);
    ->mon_ev;
    #0.5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset state", 0, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R6 mid and low pending while masked", 0, 8'h00, 0, 1, 1, 0, 0, 0);
    step("R9 enable set, all masked", 0, 8'h00, 0, 1, 1, 0, 1, 0);
    step("R2 unmask all, mid wins R10", 1, 8'h08, 0, 1, 1, 0, 0, 0);
    step("R5 top rising edge wins", 0, 8'h00, 1, 1, 1, 0, 0, 0);
    step("R5 top held after input falls", 0, 8'h00, 0, 1, 1, 0, 0, 0);
    step("R3 mask bits ignored without bit3", 1, 8'h07, 0, 1, 1, 0, 0, 0);
    step("R4 clear top latch", 1, 8'h10, 0, 1, 1, 0, 0, 0);
    step("R4 edge beats clear same cycle", 1, 8'h10, 1, 1, 1, 0, 0, 0);
    step("R5 steady high no relatch after clear", 1, 8'h10, 1, 1, 1, 0, 0, 0);
    step("R5 steady high stays clear", 0, 8'h00, 1, 0, 1, 0, 0, 0);
    step("R7 serial bit ignored without bit6", 1, 8'h80, 0, 0, 1, 0, 0, 0);
    step("R7 serial bit loaded", 1, 8'hC0, 0, 0, 1, 0, 0, 0);
    step("R7 serial bit loaded low", 1, 8'h40, 0, 0, 1, 0, 0, 0);
    step("R8 serial input in bit7", 0, 8'h00, 0, 0, 1, 1, 0, 0);
    step("R9 clear beats set", 0, 8'h00, 0, 1, 1, 0, 1, 1);
    step("R2 mask top and low, enable R10", 1, 8'h0D, 0, 1, 1, 0, 1, 0);
    step("R10 only masked low pending", 0, 8'h00, 0, 0, 1, 0, 0, 0);
    step("R10 masked top pending no request", 0, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R2 unmask top only, top wins", 1, 8'h0E, 0, 1, 1, 0, 0, 0);
    step("R9 clear drops request", 0, 8'h00, 0, 1, 1, 0, 0, 1);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule